// File: doc/BRIEF.md
# Single-Accumulator Sequential Execution Core

This block is a small in-order processor core. Its only architectural data register is an implicit accumulator that sits next to the arithmetic unit. Each instruction names one memory word. The accumulator is always the second source and the destination, except for a store, which writes the accumulator out to the named word. Instructions and data share one word-addressed memory. The core reaches that memory through a synchronous port with a one-cycle read latency. The memory itself lives outside the block.

A fixed sequence of named states carries each instruction: `S_FETCH` issues the instruction read, and `S_FWAIT` latches the returned word. `S_DECODE` classifies it and chooses the path. `S_OPFETCH` issues the operand read, and `S_OPWAIT` latches the operand. `S_EXEC` forms the result, and `S_WB` writes it to the accumulator or to memory. `S_NEXT` advances the program counter, and `S_HALTED` is the terminal state.

The transitions are fixed:
- `S_DECODE` goes to `S_OPFETCH` for load, add and multiply.
- `S_DECODE` goes to `S_WB` for store.
- `S_DECODE` goes to `S_NEXT` for an unrecognised code.
- `S_DECODE` goes to `S_HALTED` for halt.
- `S_WB` always goes to `S_NEXT`, and `S_NEXT` goes back to `S_FETCH`.
- `S_HALTED` is left only through reset.

Top module: `acc_core`

## Requirements
- R1: A synchronous reset sets the program counter and the accumulator to zero, deasserts `done` and restarts at `S_FETCH`.
- R2: An instruction word carries its operation code in bits 31:28 and its operand word address in bits ADDR_W-1:0. The codes are 0 halt, 1 load, 2 store, 3 add and 4 multiply.
- R3: Load replaces the accumulator with the addressed memory word.
- R4: Store writes the accumulator to the addressed memory word and leaves the accumulator unchanged.
- R5: Add leaves accumulator + memory word in the accumulator, modulo 2^32.
- R6: Multiply leaves the low 32 bits of accumulator * memory word in the accumulator.
- R7: Each non-halting instruction advances the program counter by exactly one. Load, add and multiply take 8 cycles, store takes 5, and the accumulator changes only on leaving `S_WB`.
- R8: Halt raises `done` and freezes the program counter at the halt's own address. From then on there are no memory reads or writes until reset.
- R9: Codes 5 to 15 change neither the accumulator nor memory, and execution continues with the next word.
- R10: Every read is followed by one wait cycle with no memory access, and a read and a write are never issued in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Word address for a read or a write |
| mem_rd | output | 1 | Read request; data returns on the next cycle |
| mem_wr | output | 1 | Write request for `mem_wdata` at `mem_addr` |
| mem_wdata | output | DATA_W | Write data (the accumulator) |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| acc_q | output | DATA_W | Current accumulator |
| pc_q | output | ADDR_W | Current program counter |
| done | output | 1 | High while halted |

## Verification
The bench keeps the defaults: DATA_W of 32 and ADDR_W of 8, which gives a 256-word memory. With 32-bit data, the operand table reaches the wrap of the sum at 2^32 and the discarded upper half of the product, for example all-ones times all-ones. The 8-bit address space holds both short programs and a chained (B+C)*(D+E) program in one memory. Cycle counts from reset to `done` pin down the wait cycles and the length of each state path.

// File: rtl/acc_pkg.sv
package acc_pkg;

    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_HALT  = 4'd0;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'd2;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'd3;
    localparam logic [OPC_W-1:0] OPC_MUL   = 4'd4;

    typedef enum logic [2:0] {
        K_HALT,
        K_LOAD,
        K_STORE,
        K_ADD,
        K_MUL,
        K_NOP
    } kind_e;

    typedef enum logic [3:0] {
        S_FETCH,
        S_FWAIT,
        S_DECODE,
        S_OPFETCH,
        S_OPWAIT,
        S_EXEC,
        S_WB,
        S_NEXT,
        S_HALTED
    } state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic [DATA_W-1:0] instr,
    output kind_e             kind,
    output logic [ADDR_W-1:0] opnd_addr
);

    localparam int OPC_LSB = DATA_W - OPC_W;

    logic [OPC_W-1:0] opc;

    assign opc       = instr[DATA_W-1:OPC_LSB];
    assign opnd_addr = instr[ADDR_W-1:0];

    // R2: fixed code points; everything else decodes as a no-op (R9)
    always_comb begin
        case (opc)
            OPC_HALT:  kind = K_HALT;
            OPC_LOAD:  kind = K_LOAD;
            OPC_STORE: kind = K_STORE;
            OPC_ADD:   kind = K_ADD;
            OPC_MUL:   kind = K_MUL;
            default:   kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  kind_e             kind,
    output logic [DATA_W-1:0] result
);

    always_comb begin
        case (kind)
            K_LOAD:  result = opnd_in;
            K_ADD:   result = acc_in + opnd_in;   // R5: wraps at DATA_W bits
            K_MUL:   result = acc_in * opnd_in;   // R6: low DATA_W bits kept
            default: result = acc_in;
        endcase
    end

endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_q,
    output logic [ADDR_W-1:0] pc_q,
    output logic              done
);

    state_e            state, state_nx;
    logic [DATA_W-1:0] ir_q;
    logic [DATA_W-1:0] opnd_q;
    logic [DATA_W-1:0] res_q;
    logic [DATA_W-1:0] alu_out;
    kind_e             kind;
    logic [ADDR_W-1:0] opnd_addr;

    acc_decode #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dec (
        .instr     (ir_q),
        .kind      (kind),
        .opnd_addr (opnd_addr)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .acc_in  (acc_q),
        .opnd_in (opnd_q),
        .kind    (kind),
        .result  (alu_out)
    );

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_FETCH;
        else     state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_FETCH:   state_nx = S_FWAIT;
            S_FWAIT:   state_nx = S_DECODE;
            S_DECODE: begin
                case (kind)
                    K_HALT:  state_nx = S_HALTED;
                    K_STORE: state_nx = S_WB;
                    K_NOP:   state_nx = S_NEXT;
                    default: state_nx = S_OPFETCH;
                endcase
            end
            S_OPFETCH: state_nx = S_OPWAIT;
            S_OPWAIT:  state_nx = S_EXEC;
            S_EXEC:    state_nx = S_WB;
            S_WB:      state_nx = S_NEXT;
            S_NEXT:    state_nx = S_FETCH;
            S_HALTED:  state_nx = S_HALTED;
            default:   state_nx = S_FETCH;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd    = (state == S_FETCH) || (state == S_OPFETCH);
        mem_wr    = (state == S_WB) && (kind == K_STORE);
        mem_addr  = (state == S_FETCH) ? pc_q : opnd_addr;
        mem_wdata = acc_q;
        done      = (state == S_HALTED);
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            acc_q  <= '0;
            ir_q   <= '0;
            opnd_q <= '0;
            res_q  <= '0;
        end else begin
            if (state == S_FWAIT)  ir_q   <= mem_rdata;
            if (state == S_OPWAIT) opnd_q <= mem_rdata;
            if (state == S_EXEC)   res_q  <= alu_out;
            if (state == S_WB && kind != K_STORE) acc_q <= res_q;
            if (state == S_NEXT)   pc_q   <= pc_q + 1'b1;
        end
    end

    // Assertions
    assert_acc_only_in_wb_R7: assert property (@(posedge clk) disable iff (rst)
        (state != S_WB) |=> $stable(acc_q));

    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_NEXT) |=> (pc_q == ADDR_W'($past(pc_q) + 1'b1)));

    assert_pc_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state != S_NEXT) |=> $stable(pc_q));

    assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_halt_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_rd && !mem_wr));

    assert_read_wait_R10: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> (!mem_rd && !mem_wr));

    assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_store_keeps_acc_R4: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> $stable(acc_q));

endmodule

// File: tb/tb_acc_core.sv
`timescale 1ns/1ps
module tb_acc_core;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd, mem_wr, done;
    logic [DATA_W-1:0] mem_wdata, acc_q;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic [ADDR_W-1:0] pc_q;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              ld_en = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic [DATA_W-1:0] ld_data = '0;
    int                halt_access = 0;
    int                tests = 0;
    int                fails = 0;

    always #2.5 clk = ~clk;

    acc_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_q(acc_q), .pc_q(pc_q), .done(done)
    );

    // Memory model: one-cycle read latency, bench loader has priority
    always @(posedge clk) begin
        if (ld_en) mem[ld_addr] <= ld_data;
        else if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (done && (mem_rd || mem_wr)) halt_access <= halt_access + 1;
    end

    function automatic logic [DATA_W-1:0] ins(input logic [3:0] op, input int a);
        return {op, {(DATA_W-4-ADDR_W){1'b0}}, ADDR_W'(a)};
    endfunction

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        ld_en = 1'b1; ld_addr = ADDR_W'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < DEPTH; i++) poke(i, '0);
    endtask

    task automatic run(output int cyc);
        @(negedge clk);
        rst = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) chk("R8 timeout", 32'(cyc), 32'(2000));
    endtask

    typedef struct packed {
        logic [3:0]        op;
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic [DATA_W-1:0] exp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{4'd3, 32'd5,          32'd7,          32'd12},   // R5
        '{4'd3, 32'hFFFF_FFFF,  32'd2,          32'd1},    // R5 wrap
        '{4'd4, 32'd6,          32'd7,          32'd42},   // R6
        '{4'd4, 32'h0001_0000,  32'h0001_0000,  32'd0},    // R6 high half lost
        '{4'd4, 32'hFFFF_FFFF,  32'hFFFF_FFFF,  32'd1},    // R6
        '{4'd1, 32'd11,         32'd22,         32'd22},   // R3
        '{4'd9, 32'd33,         32'd44,         32'd33}    // R9
    };

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n;
        // Table walk: LOAD 100; <op> 101; STORE 102; HALT
        for (int v = 0; v < NV; v++) begin
            rst = 1'b1;
            clear_mem();
            poke(0, ins(4'd1, 100));
            poke(1, ins(VEC[v].op, 101));
            poke(2, ins(4'd2, 102));
            poke(3, ins(4'd0, 0));
            poke(100, VEC[v].a);
            poke(101, VEC[v].b);
            if (v == 1) begin
                // R1: reset clears state left by the previous run
                chk("R1 acc", acc_q, '0);
                chk("R1 pc", 32'(pc_q), '0);
                chk("R1 done", 32'(done), '0);
            end
            run(n);
            chk("R3/R5/R6/R9 acc", acc_q, VEC[v].exp);
            chk("R4 stored word", mem[102], VEC[v].exp);
            chk("R7 pc at halt", 32'(pc_q), 32'd3);
            chk("R9 operand untouched", mem[101], VEC[v].b);
        end

        // R7: LOAD then HALT reaches done 11 cycles after reset release
        rst = 1'b1;
        clear_mem();
        poke(0, ins(4'd1, 40));
        poke(40, 32'hABCD_0123);
        run(n);
        chk("R7 load path cycles", 32'(n), 32'd11);
        chk("R3 load", acc_q, 32'hABCD_0123);

        // R7/R4: STORE then HALT reaches done after 8 cycles, writes 0
        rst = 1'b1;
        clear_mem();
        poke(0, ins(4'd2, 50));
        poke(50, 32'hDEAD_BEEF);
        run(n);
        chk("R7 store path cycles", 32'(n), 32'd8);
        chk("R4 store of reset acc", mem[50], 32'd0);

        // Chained (B+C)*(D+E) with B=3 C=4 D=5 E=6
        rst = 1'b1;
        clear_mem();
        poke(0, ins(4'd1, 20));
        poke(1, ins(4'd3, 32));
        poke(2, ins(4'd2, 100));
        poke(3, ins(4'd1, 48));
        poke(4, ins(4'd3, 76));
        poke(5, ins(4'd4, 100));
        poke(6, ins(4'd2, 100));
        poke(20, 32'd5); poke(32, 32'd6); poke(48, 32'd3); poke(76, 32'd4);
        run(n);
        chk("R5/R6 chain result", mem[100], 32'd77);
        chk("R7 chain pc", 32'(pc_q), 32'd7);

        // R8: halt at address 1 freezes pc and memory traffic
        rst = 1'b1;
        clear_mem();
        poke(0, ins(4'd1, 60));
        poke(60, 32'd99);
        poke(2, ins(4'd2, 61));
        halt_access = 0;
        run(n);
        repeat (20) @(negedge clk);
        chk("R8 done held", 32'(done), 32'd1);
        chk("R8 pc frozen", 32'(pc_q), 32'd1);
        chk("R8 no access", 32'(halt_access), 32'd0);
        chk("R8 no later store", mem[61], 32'd0);
        chk("R8 acc kept", acc_q, 32'd99);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule